// File: doc/BRIEF.md
# Network Controller Status and Interrupt Register

This block is the main control and status register of an Ethernet-style controller. The host reaches it through a simple write strobe with write data and a read data bus that is always valid. Datapath logic reports events as single-cycle pulses: frame received, frame sent, collision error, missed frame, memory error and transmit underflow. Each event latches into a sticky flag, and the host clears that flag by writing a one to its position. The register also holds an interrupt-enable bit, the commands that start, stop and initialise the controller, and a run-state machine. That state machine drives the receiver and transmitter enables.

The interrupt output is a level signal. It is high whenever interrupts are enabled and any flag is pending. A separate sticky edge bit records each 0-to-1 change of that level. A cause that arrives while the level is already high produces no second edge, so the service routine works from a saved snapshot. It reads the register, writes the copy back with the enable cleared, re-enables, and then services the saved causes. Command bits read as zero, so writing back a saved copy never issues a command.

Initialisation is handed to an external sequencer. The request output stays high while the block waits, and the sequencer ends the wait with a done pulse. The run-state machine has five states: STOPPED, INIT_WAIT, READY, RUNNING and TX_HALTED. The transitions are go_init, init_done, go_run, restart, underflow and stop.

Top module: `netctl_csr`

## Requirements
- R1: After reset, all flags are 0, interrupt enable is 0 and the state is STOPPED. The read value is exactly bit 17 set, and irq, rx_enable, tx_enable and seq_init_req are 0.
- R2: Event flags sit at these bits: 5 rx done, 6 tx done, 7 collision, 8 missed frame, 9 memory error and 10 underflow. Each one sets on its event pulse and is visible the cycle after the pulse. A write with a one in the flag's bit clears it, and a write with a zero there leaves it unchanged.
- R3: An event that arrives in the same cycle as a write keeps its flag set, even when that write has a one in the flag's position. So a flag that sets after a read survives the write-back of the read value.
- R4: Bit 3 is the interrupt enable, and each write loads it. irq equals the enable ANDed with the OR of flag bits 4 to 10, and bit 12 reads the irq level.
- R5: Bit 13 is the edge flag. It sets one cycle after irq rises and does not set again while irq stays high, even when new causes arrive. A write with a one in bit 13 clears it.
- R6: Bit 11 reads as the OR of the error flags in bits 7 to 10. Writing bit 11 has no effect.
- R7: Bits 0 (init), 1 (start) and 2 (stop) always read as 0. A write with zeros in those bits leaves the state unchanged, and so does writing back a value read from the register.
- R8: Writing init while STOPPED or READY enters INIT_WAIT (go_init). There, bit 16 and seq_init_req read 1. A seq_init_done pulse moves to READY (init_done) and sets flag bit 4, which is a write-one-to-clear interrupt cause.
- R9: In a write that has both init and start set, start is ignored. Start is also ignored in INIT_WAIT. Start in READY enters RUNNING (go_run), where rx_enable and tx_enable are both 1 and bits 15 and 14 read 1.
- R10: A stop write moves every state to STOPPED (stop) on the next cycle and turns off both enables. Stop takes priority over init and start in the same write.
- R11: A start write in STOPPED enters RUNNING without a new init (restart), but only if an initialisation has completed since reset. Otherwise it is ignored.
- R12: An underflow pulse in RUNNING enters TX_HALTED (underflow), where tx_enable is 0 and rx_enable is 1. Start has no effect there, and only a stop followed by a start restores transmission.
- R13: An init write in RUNNING or TX_HALTED is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Register write strobe |
| host_wdata | input | 18 | Register write data |
| host_rdata | output | 18 | Register read value |
| ev_rx_done | input | 1 | Frame received pulse |
| ev_tx_done | input | 1 | Frame sent pulse |
| ev_collision | input | 1 | Collision error pulse |
| ev_missed | input | 1 | Missed frame pulse |
| ev_mem_err | input | 1 | Memory error pulse |
| ev_underflow | input | 1 | Transmit underflow pulse |
| seq_init_done | input | 1 | Sequencer finished initialisation |
| seq_init_req | output | 1 | Initialisation requested (level) |
| rx_enable | output | 1 | Receiver enabled |
| tx_enable | output | 1 | Transmitter enabled |
| irq | output | 1 | Level interrupt |

## Verification
The hardest case to reach is the race that the saved-copy service routine exists for. An event must land in exactly the cycle in which the host writes back a snapshot that has a one in that same flag. The bench drives the write strobe and the event pulse on the same falling edge, both for the same flag and for a different one, and then reads the flag back. A second hard case is a new cause arriving while irq is already high. The bench clears the edge bit while the level stays high, adds a cause and checks that the edge bit stays clear. The enable-by-mask sweep covers every combination of the six datapath events with the enable both on and off.

// File: rtl/netctl_pkg.sv
package netctl_pkg;
    localparam int REG_W     = 18;
    localparam int NFLAG     = 7;
    localparam int B_INIT    = 0;
    localparam int B_START   = 1;
    localparam int B_STOP    = 2;
    localparam int B_IEN     = 3;
    localparam int B_FLAG_LO = 4;
    localparam int B_FLAG_HI = B_FLAG_LO + NFLAG - 1;
    localparam int B_ERRSUM  = 11;
    localparam int B_IRQ     = 12;
    localparam int B_EDGE    = 13;
    localparam int B_TXON    = 14;
    localparam int B_RXON    = 15;
    localparam int B_BUSY    = 16;
    localparam int B_STOPPED = 17;
    localparam int F_INITD   = 0;
    localparam int F_ERR_LO  = 3;

    typedef enum logic [2:0] {
        ST_STOPPED   = 3'd0,
        ST_INIT_WAIT = 3'd1,
        ST_READY     = 3'd2,
        ST_RUNNING   = 3'd3,
        ST_TX_HALTED = 3'd4
    } run_state_t;
endpackage

// File: rtl/netctl_flags.sv
module netctl_flags #(
    parameter int N = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] q_o
);
    for (genvar i = 0; i < N; i++) begin : g_flag
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q_o[i] <= 1'b0;
            else        q_o[i] <= (q_o[i] & ~clr_i[i]) | set_i[i];
        end

        // R3: a set in the same cycle as a clear wins
        p_set_sticks_r3: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[i] |=> q_o[i]);
        // R2: a clear without a set empties the flag
        p_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i[i] && !set_i[i]) |=> !q_o[i]);
        // R2: with no set and no clear the flag holds
        p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (!clr_i[i] && !set_i[i]) |=> $stable(q_o[i]));
    end
endmodule

// File: rtl/netctl_irq.sv
module netctl_irq #(
    parameter int N = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ien_i,
    input  logic [N-1:0] cause_i,
    input  logic         edge_clr_i,
    output logic         irq_o,
    output logic         edge_o
);
    logic irq_d;

    assign irq_o = ien_i & (|cause_i);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_d  <= 1'b0;
            edge_o <= 1'b0;
        end else begin
            irq_d  <= irq_o;
            edge_o <= (edge_o & ~edge_clr_i) | (irq_o & ~irq_d);
        end
    end

    // R5: the edge flag only rises right after irq was high
    p_edge_after_irq_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(edge_o) |-> $past(irq_o));
    // R5: a level held high over two cycles makes no new edge
    p_no_reedge_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && $past(irq_o) && edge_clr_i) |=> !edge_o);
endmodule

// File: rtl/netctl_runfsm.sv
module netctl_runfsm
    import netctl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_init_i,
    input  logic cmd_start_i,
    input  logic cmd_stop_i,
    input  logic underflow_i,
    input  logic seq_done_i,
    output logic busy_o,
    output logic stopped_o,
    output logic rx_on_o,
    output logic tx_on_o,
    output logic init_fin_o
);
    run_state_t state_q, state_d;
    logic       cfg_ok_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_STOPPED: begin
                if (cmd_stop_i)                     state_d = ST_STOPPED;
                else if (cmd_init_i)                state_d = ST_INIT_WAIT;
                else if (cmd_start_i && cfg_ok_q)   state_d = ST_RUNNING;
            end
            ST_INIT_WAIT: begin
                if (cmd_stop_i)                     state_d = ST_STOPPED;
                else if (seq_done_i)                state_d = ST_READY;
            end
            ST_READY: begin
                if (cmd_stop_i)                     state_d = ST_STOPPED;
                else if (cmd_init_i)                state_d = ST_INIT_WAIT;
                else if (cmd_start_i)               state_d = ST_RUNNING;
            end
            ST_RUNNING: begin
                if (cmd_stop_i)                     state_d = ST_STOPPED;
                else if (underflow_i)               state_d = ST_TX_HALTED;
            end
            ST_TX_HALTED: begin
                if (cmd_stop_i)                     state_d = ST_STOPPED;
            end
            default:                                state_d = ST_STOPPED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_STOPPED;
            cfg_ok_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (init_fin_o) cfg_ok_q <= 1'b1;
        end
    end

    always_comb begin
        busy_o     = 1'b0;
        stopped_o  = 1'b0;
        rx_on_o    = 1'b0;
        tx_on_o    = 1'b0;
        unique case (state_q)
            ST_STOPPED:   stopped_o = 1'b1;
            ST_INIT_WAIT: busy_o    = 1'b1;
            ST_READY:     ;
            ST_RUNNING:   begin rx_on_o = 1'b1; tx_on_o = 1'b1; end
            ST_TX_HALTED: rx_on_o = 1'b1;
            default:      stopped_o = 1'b1;
        endcase
        init_fin_o = (state_q == ST_INIT_WAIT) && seq_done_i && !cmd_stop_i;
    end

    // R10: stop always lands in STOPPED
    p_stop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_stop_i |=> (state_q == ST_STOPPED));
    // R9: no direct jump from INIT_WAIT to RUNNING
    p_no_start_in_init_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_INIT_WAIT) |=> (state_q != ST_RUNNING));
    // R12: a halted transmitter is never re-enabled without a stop
    p_halt_holds_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_TX_HALTED && !cmd_stop_i) |=> (state_q == ST_TX_HALTED));
    // R13: init in a running state does not enter INIT_WAIT
    p_init_ignored_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUNNING || state_q == ST_TX_HALTED) |=> (state_q != ST_INIT_WAIT));
endmodule

// File: rtl/netctl_csr.sv
module netctl_csr
    import netctl_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             host_wr,
    input  logic [REG_W-1:0] host_wdata,
    output logic [REG_W-1:0] host_rdata,
    input  logic             ev_rx_done,
    input  logic             ev_tx_done,
    input  logic             ev_collision,
    input  logic             ev_missed,
    input  logic             ev_mem_err,
    input  logic             ev_underflow,
    input  logic             seq_init_done,
    output logic             seq_init_req,
    output logic             rx_enable,
    output logic             tx_enable,
    output logic             irq
);
    logic             ien_q;
    logic [NFLAG-1:0] flag_set, flag_clr, flags;
    logic             busy, stopped, init_fin, edge_flag;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       ien_q <= 1'b0;
        else if (host_wr) ien_q <= host_wdata[B_IEN];
    end

    assign flag_clr = host_wr ? host_wdata[B_FLAG_HI:B_FLAG_LO] : '0;
    assign flag_set = {ev_underflow, ev_mem_err, ev_missed, ev_collision,
                       ev_tx_done, ev_rx_done, init_fin};

    netctl_flags #(.N(NFLAG)) u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (flag_set),
        .clr_i (flag_clr),
        .q_o   (flags)
    );

    netctl_irq #(.N(NFLAG)) u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .ien_i      (ien_q),
        .cause_i    (flags),
        .edge_clr_i (host_wr & host_wdata[B_EDGE]),
        .irq_o      (irq),
        .edge_o     (edge_flag)
    );

    netctl_runfsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_init_i  (host_wr & host_wdata[B_INIT]),
        .cmd_start_i (host_wr & host_wdata[B_START] & ~host_wdata[B_INIT]),
        .cmd_stop_i  (host_wr & host_wdata[B_STOP]),
        .underflow_i (ev_underflow),
        .seq_done_i  (seq_init_done),
        .busy_o      (busy),
        .stopped_o   (stopped),
        .rx_on_o     (rx_enable),
        .tx_on_o     (tx_enable),
        .init_fin_o  (init_fin)
    );

    assign seq_init_req = busy;

    always_comb begin
        host_rdata                        = '0;
        host_rdata[B_IEN]                 = ien_q;
        host_rdata[B_FLAG_HI:B_FLAG_LO]   = flags;
        host_rdata[B_ERRSUM]              = |flags[NFLAG-1:F_ERR_LO];
        host_rdata[B_IRQ]                 = irq;
        host_rdata[B_EDGE]                = edge_flag;
        host_rdata[B_TXON]                = tx_enable;
        host_rdata[B_RXON]                = rx_enable;
        host_rdata[B_BUSY]                = busy;
        host_rdata[B_STOPPED]             = stopped;
    end

    // R4: a write that clears the enable silences irq next cycle
    p_ien_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && !host_wdata[B_IEN]) |=> !irq);
    // R8: a done pulse while waiting raises the init-done flag
    p_initdone_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_init_req && seq_init_done && !(host_wr && host_wdata[B_STOP]))
            |=> (flags[F_INITD] && !seq_init_req));
    // R12: underflow while running turns only the transmitter off
    p_uflo_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_enable && ev_underflow && !(host_wr && host_wdata[B_STOP]))
            |=> (!tx_enable && rx_enable));
    // R7: a write with no command bits keeps the enables steady
    p_nocmd_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_wdata[2:0] == 3'b000 && !ev_underflow && !seq_init_done)
            |=> ($stable(rx_enable) && $stable(tx_enable) && $stable(seq_init_req)));
endmodule

// File: tb/test_netctl_csr.sv
module test_netctl_csr;
    localparam int W = 18;
    logic clk = 1'b0, rst_n = 1'b0;
    logic host_wr = 1'b0;
    logic [W-1:0] host_wdata = '0, host_rdata;
    logic ev_rx_done = 0, ev_tx_done = 0, ev_collision = 0, ev_missed = 0;
    logic ev_mem_err = 0, ev_underflow = 0, seq_init_done = 0;
    logic seq_init_req, rx_enable, tx_enable, irq;
    int n_chk = 0, n_bad = 0, cyc = 0;

    always #2 clk = ~clk;

    netctl_csr i_netctl_csr (.*);

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [W-1:0] d);
        host_wr = 1'b1; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0; host_wdata = '0;
    endtask

    task automatic pulse(logic [5:0] m);
        {ev_underflow, ev_mem_err, ev_missed, ev_collision, ev_tx_done, ev_rx_done} = m;
        @(negedge clk);
        {ev_underflow, ev_mem_err, ev_missed, ev_collision, ev_tx_done, ev_rx_done} = '0;
    endtask

    function automatic logic [W-1:0] clr_all(logic ien);
        return W'((18'h7F << 4) | (18'h1 << 13) | (18'(ien) << 3));
    endfunction

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0d expected<150000", cyc);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] saved;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 rdata", 32'(host_rdata), 32'h20000);
        chk("R1 outs", {28'd0, irq, rx_enable, tx_enable, seq_init_req}, 0);

        // R2 per-flag set / write-0 / write-1
        for (int b = 0; b < 6; b++) begin
            pulse(6'(1 << b));
            chk("R2 set", 32'(host_rdata[10:4]), 32'(1 << (b + 1)));
            wr('0);
            chk("R2 write0 keeps", 32'(host_rdata[b+5]), 1);
            wr(W'(1 << (b + 5)));
            chk("R2 write1 clears", 32'(host_rdata[10:4]), 0);
        end

        // R4 / R6 sweep over every event combination and enable value
        for (int e = 0; e < 2; e++) begin
            for (int m = 0; m < 64; m++) begin
                wr(clr_all(e[0]));
                pulse(6'(m));
                chk("R4 irq", 32'(irq), 32'(e != 0 && m != 0));
                chk("R4 irq bit", 32'(host_rdata[12]), 32'(e != 0 && m != 0));
                chk("R6 errsum", 32'(host_rdata[11]), 32'((m >> 2) != 0));
            end
        end
        // R6 write to bit 11 has no effect
        wr(clr_all(0));
        pulse(6'b000100);
        wr(W'(1 << 11));
        chk("R6 errsum ro", 32'(host_rdata[11]), 1);
        chk("R6 flag kept", 32'(host_rdata[7]), 1);

        // R5 edge capture
        wr(clr_all(1));
        @(negedge clk);
        wr(W'((1 << 13) | (1 << 3)));
        chk("R5 edge cleared", 32'(host_rdata[13]), 0);
        pulse(6'b000001);
        chk("R5 irq up", 32'(irq), 1);
        @(negedge clk);
        chk("R5 edge set", 32'(host_rdata[13]), 1);
        wr(W'((1 << 13) | (1 << 3)));
        pulse(6'b000010);
        @(negedge clk);
        chk("R5 no re-edge", 32'(host_rdata[13]), 0);
        chk("R5 irq held", 32'(irq), 1);

        // R3 service race: event during write-back of saved copy
        saved = host_rdata;
        host_wr = 1'b1; host_wdata = saved & ~W'(1 << 3);
        ev_rx_done = 1'b1; ev_collision = 1'b1;
        @(negedge clk);
        host_wr = 1'b0; host_wdata = '0; ev_rx_done = 0; ev_collision = 0;
        chk("R3 same-flag survives", 32'(host_rdata[5]), 1);
        chk("R3 new flag survives", 32'(host_rdata[7]), 1);
        chk("R3 saved flag cleared", 32'(host_rdata[6]), 0);
        chk("R4 irq off", 32'(irq), 0);
        wr(W'(1 << 3));
        chk("R4 irq back", 32'(irq), 1);
        wr(clr_all(0));

        // R11 start without prior init ignored
        wr(W'(1 << 1));
        chk("R11 start ignored", 32'(host_rdata[17:14]), 32'h8);
        // R9 init+start: only init
        wr(W'(3));
        chk("R9 init only", 32'(host_rdata[17:14]), 32'h4);
        chk("R8 req", 32'(seq_init_req), 1);
        wr(W'(1 << 1));
        chk("R9 start in init", 32'(host_rdata[17:14]), 32'h4);
        seq_init_done = 1'b1; @(negedge clk); seq_init_done = 1'b0;
        chk("R8 ready", 32'(host_rdata[17:14]), 0);
        chk("R8 flag", 32'(host_rdata[4]), 1);
        wr(W'(1 << 4));
        chk("R8 flag w1c", 32'(host_rdata[4]), 0);
        // R7 write-back and command read value
        wr(host_rdata);
        chk("R7 writeback", 32'(host_rdata[17:14]), 0);
        chk("R7 cmd read 0", 32'(host_rdata[2:0]), 0);
        // R9 go_run
        wr(W'(1 << 1));
        chk("R9 run", {30'd0, rx_enable, tx_enable}, 3);
        wr(host_rdata);
        chk("R7 writeback run", 32'(host_rdata[17:14]), 32'h3);
        wr(W'(1));
        chk("R13 init in run", {30'd0, seq_init_req, tx_enable}, 1);
        // R12 underflow
        pulse(6'b100000);
        chk("R12 halted", {30'd0, rx_enable, tx_enable}, 2);
        wr(W'(1 << 1));
        chk("R12 start no effect", 32'(tx_enable), 0);
        wr(W'(1));
        chk("R13 init in halted", 32'(seq_init_req), 0);
        wr(W'(1 << 2));
        chk("R10 stopped", 32'(host_rdata[17:14]), 32'h8);
        wr(W'(1 << 1));
        chk("R11 restart", {30'd0, rx_enable, tx_enable}, 3);
        // R10 stop beats init in same write
        wr(W'(5));
        chk("R10 stop priority", 32'(host_rdata[17:14]), 32'h8);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule